// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Check

This block is the control unit of a small accumulator machine. Code and data sit in one shared read/write memory outside the block. It steps each instruction through a fixed set of cycle states: next-address calculation, instruction fetch, decode, operand address calculation, operand fetch, data operation and operand store. The operand states are visited only when the decoded instruction needs them. Every instruction ends in an interrupt-check state. There a pending, unmasked interrupt saves the program counter and the accumulator in shadow registers and redirects execution to a handler vector. A return instruction later restores both and resumes the interrupted program.

The block owns the program counter, memory address register, memory buffer register, instruction register and accumulator. The memory port has a fixed timing and no back-pressure. The address is always the memory address register. A read word must appear on the read-data input in the cycle after its address is presented. A write happens in the cycle where the write enable is high. There is no valid/ready handshake, because neither side can stall. The interrupt request, vector, acknowledge and mask outputs are plain control pins.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is high, the PC reads 0, the cycle state reads 0 and the mask output is 1. After reset is released, sequencing starts in the address-calculation state. Cycle state codes are: 0 address calculation, 1 fetch, 2 decode, 3 operand address, 4 operand fetch, 5 data operation, 6 operand store, 7 interrupt check.
- R2: In the fetch state the memory address equals the PC value of the instruction. In decode the PC reads that value plus one. After decode the instruction register holds the fetched word.
- R3: The opcode is instruction bits [15:12]: 0 load, 1 store, 2 add, 3 jump, 4 return-from-interrupt. The operand address is bits [11:0]. Load and add visit states 0,1,2,3,4,5,7 in that order.
- R4: Store visits states 0,1,2,3,5,6,7, skipping operand fetch. It writes the accumulator to the operand address.
- R5: Jump and return visit states 0,1,2,5,7. Any other opcode is a no-operation that visits 0,1,2,7 and leaves the accumulator unchanged.
- R6: Load sets the accumulator to the addressed word. Add adds the addressed word to the accumulator modulo 2^16.
- R7: Jump sets the PC to the operand address field.
- R8: In the interrupt-check state, a pending and unmasked interrupt raises the acknowledge for that one cycle. It saves the PC and accumulator and loads the PC with the vector, so the next fetch comes from the vector.
- R9: Taking an interrupt sets the mask. While it is set, a pending request raises no acknowledge and causes no redirect.
- R10: Return-from-interrupt restores the saved PC and accumulator, clears the mask, and the program resumes at the saved address.
- R11: The first instruction after reset completes with interrupts masked, even if a request is pending.
- R12: The write enable is high only in the operand store state, exactly once per store instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| irq_pending | input | 1 | Interrupt request level |
| irq_vector | input | 12 | Handler start address |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| irq_masked | output | 1 | Interrupts currently masked |
| cyc_state | output | 3 | Current cycle state code |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |

## Verification
The sequencer runs four instruction classes: operand reads, stores, control transfers and unknown opcodes. Each class is checked for the exact state trace it walks, so a missing or extra operand state shows up as a different trace. An add whose sum overflows 16 bits separates a modulo add from a plain load. A request held high from reset onward separates the boot mask, the handler mask and the unmasked case. A request raised again after the return confirms that the mask was really cleared and the context restored.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_ADDR    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_DECODE  = 3'd2,
    ST_OPADDR  = 3'd3,
    ST_OPFETCH = 3'd4,
    ST_EXEC    = 3'd5,
    ST_STORE   = 3'd6,
    ST_INTCHK  = 3'd7
  } cyc_state_t;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd0;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OPC_JUMP  = 4'd3;
  localparam logic [OP_W-1:0] OPC_RETI  = 4'd4;
endpackage

// File: rtl/iseq_decode.sv
module iseq_decode
  import iseq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            need_addr,
  output logic            need_read,
  output logic            need_write,
  output logic            do_add,
  output logic            do_jump,
  output logic            do_reti
);
  always_comb begin
    need_addr  = 1'b0;
    need_read  = 1'b0;
    need_write = 1'b0;
    do_add     = 1'b0;
    do_jump    = 1'b0;
    do_reti    = 1'b0;
    case (opcode)
      OPC_LOAD:  begin need_addr = 1'b1; need_read = 1'b1; end
      OPC_ADD:   begin need_addr = 1'b1; need_read = 1'b1; do_add = 1'b1; end
      OPC_STORE: begin need_addr = 1'b1; need_write = 1'b1; end
      OPC_JUMP:  do_jump = 1'b1;
      OPC_RETI:  do_reti = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/iseq_fsm.sv
module iseq_fsm
  import iseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       need_addr,
  input  logic       need_read,
  input  logic       need_write,
  input  logic       do_jump,
  input  logic       do_reti,
  input  logic       irq_pending,
  output cyc_state_t state,
  output logic       take_irq,
  output logic       masked
);
  cyc_state_t next_state;
  logic       boot_q;
  logic       handler_q;

  always_comb begin
    next_state = ST_ADDR;
    case (state)
      ST_ADDR:    next_state = ST_FETCH;
      ST_FETCH:   next_state = ST_DECODE;
      ST_DECODE: begin
        if (need_addr)                next_state = ST_OPADDR;
        else if (do_jump || do_reti)  next_state = ST_EXEC;
        else                          next_state = ST_INTCHK;
      end
      ST_OPADDR:  next_state = need_read ? ST_OPFETCH : ST_EXEC;
      ST_OPFETCH: next_state = ST_EXEC;
      ST_EXEC:    next_state = need_write ? ST_STORE : ST_INTCHK;
      ST_STORE:   next_state = ST_INTCHK;
      ST_INTCHK:  next_state = ST_ADDR;
      default:    next_state = ST_ADDR;
    endcase
  end

  assign masked   = boot_q | handler_q;
  assign take_irq = (state == ST_INTCHK) && irq_pending && !masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ADDR;
      boot_q    <= 1'b1;
      handler_q <= 1'b0;
    end else begin
      state <= next_state;
      if (state == ST_INTCHK) boot_q <= 1'b0;
      if (take_irq) handler_q <= 1'b1;
      else if (state == ST_EXEC && do_reti) handler_q <= 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (state == ST_ADDR && masked));

  a_r3_opfetch_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPFETCH) |-> ($past(state) == ST_OPADDR));

  a_r4_store_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE) |-> ($past(state) == ST_EXEC));

  a_r9_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(handler_q) |-> ($past(state) == ST_INTCHK));

  a_r10_unmask_on_return: assert property (@(posedge clk) disable iff (rst)
    $fell(handler_q) |-> ($past(state) == ST_EXEC && $past(do_reti)));
endmodule

// File: rtl/iseq_datapath.sv
module iseq_datapath
  import iseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_state_t        state,
  input  logic              need_read,
  input  logic              need_write,
  input  logic              do_add,
  input  logic              do_jump,
  input  logic              do_reti,
  input  logic              take_irq,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mbr,
  output logic [WORD_W-1:0] ir,
  output logic [WORD_W-1:0] acc,
  output logic              mem_we
);
  logic [ADDR_W-1:0] shadow_pc;
  logic [WORD_W-1:0] shadow_acc;
  logic [ADDR_W-1:0] operand_addr;

  assign operand_addr = ir[ADDR_W-1:0];
  assign mem_we       = (state == ST_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      mar        <= '0;
      mbr        <= '0;
      ir         <= '0;
      acc        <= '0;
      shadow_pc  <= '0;
      shadow_acc <= '0;
    end else begin
      case (state)
        ST_ADDR:   mar <= pc;
        ST_FETCH:  pc <= pc + 1'b1;
        ST_DECODE: begin
          ir  <= mem_rdata;
          mbr <= mem_rdata;
        end
        ST_OPADDR: mar <= operand_addr;
        ST_EXEC: begin
          if (need_read) begin
            mbr <= mem_rdata;
            acc <= do_add ? (acc + mem_rdata) : mem_rdata;
          end
          if (need_write) mbr <= acc;
          if (do_jump)    pc  <= operand_addr;
          if (do_reti) begin
            pc  <= shadow_pc;
            acc <= shadow_acc;
          end
        end
        ST_INTCHK: begin
          if (take_irq) begin
            shadow_pc  <= pc;
            shadow_acc <= acc;
            pc         <= irq_vector;
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + ADDR_W'(1)));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && do_jump) |=> (pc == $past(operand_addr)));

  a_r8_vector_load: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> (pc == $past(irq_vector)));

  a_r12_write_slot: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(state) == ST_EXEC));
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import iseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              irq_pending,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic              irq_ack,
  output logic              irq_masked,
  output logic [2:0]        cyc_state,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] ir
);
  localparam int OP_LSB = WORD_W - OP_W;

  cyc_state_t       state;
  logic [OP_W-1:0]  opcode;
  logic             need_addr, need_read, need_write;
  logic             do_add, do_jump, do_reti;
  logic             take_irq;

  // decode straight from the returning word in decode, from IR afterwards
  assign opcode = (state == ST_DECODE) ? mem_rdata[WORD_W-1:OP_LSB]
                                       : ir[WORD_W-1:OP_LSB];

  iseq_decode u_decode (
    .opcode     (opcode),
    .need_addr  (need_addr),
    .need_read  (need_read),
    .need_write (need_write),
    .do_add     (do_add),
    .do_jump    (do_jump),
    .do_reti    (do_reti)
  );

  iseq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .need_addr   (need_addr),
    .need_read   (need_read),
    .need_write  (need_write),
    .do_jump     (do_jump),
    .do_reti     (do_reti),
    .irq_pending (irq_pending),
    .state       (state),
    .take_irq    (take_irq),
    .masked      (irq_masked)
  );

  iseq_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .need_read  (need_read),
    .need_write (need_write),
    .do_add     (do_add),
    .do_jump    (do_jump),
    .do_reti    (do_reti),
    .take_irq   (take_irq),
    .mem_rdata  (mem_rdata),
    .irq_vector (irq_vector),
    .pc         (pc),
    .mar        (mem_addr),
    .mbr        (mem_wdata),
    .ir         (ir),
    .acc        (acc),
    .mem_we     (mem_we)
  );

  assign irq_ack   = take_irq;
  assign cyc_state = state;
endmodule

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq_pending = 1'b0;
  logic [11:0] irq_vector = 12'h040;
  logic        irq_ack, irq_masked;
  logic [2:0]  cyc_state;
  logic [11:0] pc_o;
  logic [15:0] acc_o, ir_o;

  int checks = 0;
  int failures = 0;
  int we_count = 0;
  logic [15:0] mem [0:255];

  instr_cycle_seq uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .irq_masked(irq_masked),
    .cyc_state(cyc_state), .pc(pc_o), .acc(acc_o), .ir(ir_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) if (!rst && mem_we) we_count++;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1 pc in reset", {20'd0, pc_o}, 32'd0);
    check_eq("R1 state in reset", {29'd0, cyc_state}, 32'd0);
    check_eq("R1 mask in reset", {31'd0, irq_masked}, 32'd1);
    check_eq("R12 no write in reset", {31'd0, mem_we}, 32'd0);
    rst = 1'b0;
    we_count = 0;
  endtask

  // Walks one instruction from address calculation to interrupt check,
  // then advances to the next address-calculation cycle.
  task automatic step_instr(output logic [31:0] seq, output logic [11:0] faddr,
                            output logic [11:0] pc_dec, output logic ack,
                            output logic [15:0] acc_i, output logic [11:0] pc_i,
                            output logic msk);
    int guard = 0;
    seq = '0; faddr = '0; pc_dec = '0; ack = 1'b0; acc_i = '0; pc_i = '0; msk = 1'b0;
    while (guard < 20) begin
      seq = {seq[27:0], 1'b0, cyc_state};
      if (cyc_state == 3'd1) faddr = mem_addr;
      if (cyc_state == 3'd2) pc_dec = pc_o;
      if (cyc_state == 3'd7) begin
        ack = irq_ack; acc_i = acc_o; pc_i = pc_o; msk = irq_masked;
        break;
      end
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic test_operand_ops();
    logic [31:0] seq; logic [11:0] fa, pd, pi; logic ak, mk; logic [15:0] ai;
    clear_mem();
    mem[0] = 16'h0080; mem[1] = 16'h2081; mem[2] = 16'h1082; mem[3] = 16'h3003;
    mem[8'h80] = 16'h1234; mem[8'h81] = 16'hF000;
    irq_pending = 1'b0;
    do_reset();
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R3 load trace", seq, 32'h0123457);
    check_eq("R2 fetch address", {20'd0, fa}, 32'h0);
    check_eq("R2 pc incremented", {20'd0, pd}, 32'h1);
    check_eq("R2 ir loaded", {16'd0, ir_o}, 32'h0080);
    check_eq("R6 load value", {16'd0, ai}, 32'h1234);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R3 add trace", seq, 32'h0123457);
    check_eq("R6 add wraps", {16'd0, ai}, 32'h0234);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R4 store trace", seq, 32'h0123567);
    check_eq("R4 stored word", {16'd0, mem[8'h82]}, 32'h0234);
    check_eq("R12 one write", we_count, 32'd1);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R5 jump trace", seq, 32'h01257);
    check_eq("R7 jump target", {20'd0, pi}, 32'h3);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R7 refetch at target", {20'd0, fa}, 32'h3);
    check_eq("R12 no further write", we_count, 32'd1);
  endtask

  task automatic test_noops();
    logic [31:0] seq; logic [11:0] fa, pd, pi; logic ak, mk; logic [15:0] ai;
    clear_mem();
    mem[0] = 16'h0080; mem[1] = 16'hF123; mem[2] = 16'h7000; mem[3] = 16'h3003;
    mem[8'h80] = 16'h5A5A;
    irq_pending = 1'b0;
    do_reset();
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R5 noop F trace", seq, 32'h0127);
    check_eq("R5 noop keeps acc", {16'd0, ai}, 32'h5A5A);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R5 noop 7 trace", seq, 32'h0127);
    check_eq("R5 noop pc", {20'd0, pi}, 32'h3);
    check_eq("R5 noop acc again", {16'd0, ai}, 32'h5A5A);
  endtask

  task automatic test_interrupts();
    logic [31:0] seq; logic [11:0] fa, pd, pi; logic ak, mk; logic [15:0] ai;
    clear_mem();
    mem[0] = 16'h0080; mem[1] = 16'h2081; mem[2] = 16'h3002;
    mem[8'h40] = 16'h0083; mem[8'h41] = 16'h1084; mem[8'h42] = 16'h4000;
    mem[8'h80] = 16'h0011; mem[8'h81] = 16'h0001; mem[8'h83] = 16'h0AAA;
    irq_vector = 12'h040;
    irq_pending = 1'b1;
    do_reset();
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R11 no ack on first instr", {31'd0, ak}, 32'd0);
    check_eq("R11 pc continues", {20'd0, pc_o}, 32'h1);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R8 ack raised", {31'd0, ak}, 32'd1);
    check_eq("R8 acc before save", {16'd0, ai}, 32'h0012);
    check_eq("R8 pc at vector", {20'd0, pc_o}, 32'h040);
    check_eq("R9 masked in handler", {31'd0, irq_masked}, 32'd1);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R8 fetch from vector", {20'd0, fa}, 32'h040);
    check_eq("R9 no ack while masked", {31'd0, ak}, 32'd0);
    check_eq("R9 handler continues", {20'd0, pc_o}, 32'h041);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R9 no ack on store", {31'd0, ak}, 32'd0);
    check_eq("R4 handler store", {16'd0, mem[8'h84]}, 32'h0AAA);
    irq_pending = 1'b0;
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R10 return trace", seq, 32'h01257);
    check_eq("R10 acc restored", {16'd0, ai}, 32'h0012);
    check_eq("R10 pc restored", {20'd0, pi}, 32'h2);
    check_eq("R10 unmasked", {31'd0, mk}, 32'd0);
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R10 resumed fetch", {20'd0, fa}, 32'h2);
    irq_pending = 1'b1;
    step_instr(seq, fa, pd, ak, ai, pi, mk);
    check_eq("R8 ack after return", {31'd0, ak}, 32'd1);
    check_eq("R8 second redirect", {20'd0, pc_o}, 32'h040);
    irq_pending = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    test_operand_ops();
    test_noops();
    test_interrupts();
    summary();
    $finish;
  end
endmodule